// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash model. It watches write bus cycles, each carrying an address, a data byte and two active-low strobes (chip enable and write enable), and recognises the multi-cycle unlock sequences that guard every destructive operation. A recognised sequence raises a one-cycle request: program one cell, erase the whole array, erase one sector, or enter the identification mode. A small behavioural cell array executes these requests. Erase runs for a fixed, configurable number of clocks. While an erase runs, all write cycles are ignored and every read returns status instead of data.

A write cycle is committed when it ends. This is the moment one of the two strobes returns high after both were low together. The two magic unlock addresses depend on a word/byte mode pin. Reads use a plain request pin and return registered data one clock later. No stream interface fits this control-register style of bus, so there is no back-pressure: reads are always accepted and are never stalled.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is not busy, it is in normal read mode, and every cell reads 0xFF.
- R2: In word mode (byte_mode=0), the cycles AA@0x5555, 55@0x2AAA, A0@0x5555 and then data D at address P program cell P[ARR_AW-1:0]. The new value is old AND D, so bits can only go from 1 to 0.
- R3: In byte mode (byte_mode=1), the unlock addresses are 0xAAAA for the first unlock and 0x5555 for the second. In this mode the word-mode addresses do not unlock.
- R4: A cycle with a wrong address or wrong data at any step of a sequence returns the decoder to idle. It has no side effect, and the cycle that follows is not treated as program data. An erase confirm byte other than 0x10 or 0x30 starts nothing.
- R5: A cycle with data 0xF0 at any address, except the program-data cycle, aborts any partial sequence and leaves identification mode.
- R6: After the cycles AA@UL1, 55@UL2, 90@UL1, reads return IDs instead of cell data. Read address low byte 0x00 returns MFR_ID, 0x01 returns DEV_ID, and any other offset returns 0x00.
- R7: The cycles AA@UL1, 55@UL2, 80@UL1, AA@UL1, 55@UL2, 10@UL1 hold busy high for exactly ERASE_CYCLES clocks. After that, every cell reads 0xFF.
- R8: The same sequence with a final 0x30 at any address erases only the sector selected by that address's bits [ARR_AW-1:ARR_AW-SECT_W]. Cells in other sectors are unchanged.
- R9: A read while busy returns status. Bit 7 is 0, bits 5..0 are 0, and bit 6 changes on every successive read.
- R10: While busy, write cycles are ignored. A full program sequence issued during an erase leaves its target cell unchanged.
- R11: A cycle counts only when ce_n and we_n are low together. Pulsing we_n with ce_n held high has no effect.
- R12: rd_valid is high exactly in the cycle after a cycle with rd_en high, and rd_data is valid then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Cell data, ID or status |
| busy | output | 1 | Erase in progress |

## Verification
Programming is swept over every cell twice with two arithmetic patterns. This shows that writes hit the addressed cell only and that bits combine by AND rather than by overwrite. Every sector is erased in turn after a fresh fill, alternating word and byte mode, which tells apart sector selection and the two unlock address sets. Corrupted sequences are exercised with a wrong address, wrong data, an F0 abort, a bad confirm and a strobe without chip enable. Each is followed by a data cycle that would program a cell if the decoder had not returned to idle. One erase is timed cycle by cycle. During another erase, status reads are taken and a program is attempted, so that the lockout can be seen at the ports.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [15:0] WORD_UL1 = 16'h5555;
  localparam logic [15:0] WORD_UL2 = 16'h2AAA;
  localparam logic [15:0] BYTE_UL1 = 16'hAAAA;
  localparam logic [15:0] BYTE_UL2 = 16'h5555;
  localparam logic [7:0]  D_KEY1   = 8'hAA;
  localparam logic [7:0]  D_KEY2   = 8'h55;
  localparam logic [7:0]  OP_PROG  = 8'hA0;
  localparam logic [7:0]  OP_IDENT = 8'h90;
  localparam logic [7:0]  OP_ESET  = 8'h80;
  localparam logic [7:0]  OP_ABORT = 8'hF0;
  localparam logic [7:0]  OP_CHIP  = 8'h10;
  localparam logic [7:0]  OP_SECT  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PDATA, ST_ESET, ST_EK1, ST_EK2
  } seq_state_t;
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);
  logic act, act_q, act_qq;
  assign act = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      act_qq <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
    end else begin
      act_q  <= act;
      act_qq <= act_q;
      if (act) begin
        c_addr <= addr;
        c_data <= data;
      end
    end
  end

  assign commit = act_qq & ~act_q;
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              busy,
  input  logic              commit,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  output logic              prog_we,
  output logic              chip_erase,
  output logic              sect_erase,
  output logic              ident_mode
);
  seq_state_t st, nxt;
  logic [15:0] a16, ul1, ul2;
  logic [7:0]  d8;
  logic        id_set, id_clr;

  assign a16 = c_addr[15:0];
  assign d8  = c_data[7:0];
  assign ul1 = byte_mode ? BYTE_UL1 : WORD_UL1;
  assign ul2 = byte_mode ? BYTE_UL2 : WORD_UL2;

  always_comb begin
    nxt = st;
    prog_we = 1'b0;
    chip_erase = 1'b0;
    sect_erase = 1'b0;
    id_set = 1'b0;
    id_clr = 1'b0;
    if (commit && !busy) begin
      if (st != ST_PDATA && d8 == OP_ABORT) begin
        nxt = ST_IDLE;
        id_clr = 1'b1;
      end else begin
        nxt = ST_IDLE;
        case (st)
          ST_IDLE: if (a16 == ul1 && d8 == D_KEY1) nxt = ST_K1;
          ST_K1:   if (a16 == ul2 && d8 == D_KEY2) nxt = ST_K2;
          ST_K2:   if (a16 == ul1) begin
            if (d8 == OP_PROG) nxt = ST_PDATA;
            else if (d8 == OP_ESET) nxt = ST_ESET;
            else if (d8 == OP_IDENT) id_set = 1'b1;
          end
          ST_PDATA: prog_we = 1'b1;
          ST_ESET: if (a16 == ul1 && d8 == D_KEY1) nxt = ST_EK1;
          ST_EK1:  if (a16 == ul2 && d8 == D_KEY2) nxt = ST_EK2;
          ST_EK2: begin
            if (d8 == OP_CHIP && a16 == ul1) chip_erase = 1'b1;
            else if (d8 == OP_SECT) sect_erase = 1'b1;
          end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ident_mode <= 1'b0;
    end else begin
      st <= nxt;
      if (id_clr) ident_mode <= 1'b0;
      else if (id_set) ident_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int ERASE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYCLES - 1);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int ARR_AW = 4,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ARR_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fill,
  input  logic              fill_all,
  input  logic [SECT_W-1:0] fill_sect,
  input  logic [ARR_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam int SSHIFT = ARR_AW - SECT_W;
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(i >> SSHIFT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells[i] <= '1;
      else if (fill && (fill_all || fill_sect == MY_SECT)) cells[i] <= '1;
      else if (we && waddr == ARR_AW'(i)) cells[i] <= cells[i] & wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 4,
  parameter int SECT_W = 2,
  parameter int ERASE_CYCLES = 64,
  parameter logic [7:0] MFR_ID = 8'h40,
  parameter logic [7:0] DEV_ID = 8'hB3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic              commit, prog_we, chip_erase, sect_erase, ident_mode;
  logic              er_start, er_done, er_all, tog;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data, arr_rdata;
  logic [SECT_W-1:0] er_sect;

  flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(wr_addr),
    .data(wr_data), .commit(commit), .c_addr(c_addr), .c_data(c_data));

  flash_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .busy(busy),
    .commit(commit), .c_addr(c_addr), .c_data(c_data), .prog_we(prog_we),
    .chip_erase(chip_erase), .sect_erase(sect_erase), .ident_mode(ident_mode));

  assign er_start = chip_erase | sect_erase;

  flash_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(er_start), .busy(busy), .done(er_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_all  <= 1'b0;
      er_sect <= '0;
    end else if (er_start && !busy) begin
      er_all  <= chip_erase;
      er_sect <= c_addr[ARR_AW-1 -: SECT_W];
    end
  end

  flash_cell_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(prog_we), .waddr(c_addr[ARR_AW-1:0]),
    .wdata(c_data), .fill(er_done), .fill_all(er_all), .fill_sect(er_sect),
    .raddr(rd_addr[ARR_AW-1:0]), .rdata(arr_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (er_start && !busy) tog <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rd_data    <= '0;
          rd_data[6] <= tog;
          tog        <= ~tog;
        end else if (ident_mode) begin
          if (rd_addr[7:0] == 8'h00) rd_data <= DATA_W'(MFR_ID);
          else if (rd_addr[7:0] == 8'h01) rd_data <= DATA_W'(DEV_ID);
          else rd_data <= '0;
        end else begin
          rd_data <= arr_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              prog_we,
  input logic              chip_erase,
  input logic              sect_erase
);
  assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_we, chip_erase, sect_erase}));

  assert_prog_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_we);

  assert_erase_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase || sect_erase) && !busy |=> busy);

  assert_rd_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_rd_valid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_status_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && busy |=> (rd_data[7] == 1'b0 && rd_data[5:0] == 6'd0));
endmodule

bind flash_cmd_fsm flash_cmd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .prog_we(prog_we), .chip_erase(chip_erase),
  .sect_erase(sect_erase));

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  localparam int LEN = 40;
  localparam int NC = 16;
  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0, ce_n = 1'b1, we_n = 1'b1, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic        rd_valid, busy;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_mem [NC];

  always #10 clk = ~clk;

  flash_cmd_fsm #(.ERASE_CYCLES(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .ce_n(ce_n), .we_n(we_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ul1(input logic bm); return bm ? 16'hAAAA : 16'h5555; endfunction
  function automatic logic [15:0] ul2(input logic bm); return bm ? 16'h5555 : 16'h2AAA; endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic use_ce = 1'b1);
    @(negedge clk);
    wr_addr = a; wr_data = d; ce_n = ~use_ce; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1, "R12 rd_valid", rd_valid, 1);
    v = rd_data;
  endtask

  task automatic prog(input logic bm, input logic [15:0] a, input logic [7:0] d);
    bus_wr(ul1(bm), 8'hAA); bus_wr(ul2(bm), 8'h55); bus_wr(ul1(bm), 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase(input logic bm, input logic [15:0] a, input logic [7:0] conf);
    bus_wr(ul1(bm), 8'hAA); bus_wr(ul2(bm), 8'h55); bus_wr(ul1(bm), 8'h80);
    bus_wr(ul1(bm), 8'hAA); bus_wr(ul2(bm), 8'h55); bus_wr(a, conf);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int i = 0; i < NC; i++) begin
      rd(16'(i), v);
      check(v === exp_mem[i], tag, v, exp_mem[i]);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 91 + 92) & 255);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    int cnt;
    for (int i = 0; i < NC; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", busy, 0);
    check_all("R1 erased");

    // R2 program sweep twice, AND semantics
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < NC; a++) begin
        prog(1'b0, 16'h0100 | 16'(a), pat(a, k));
        exp_mem[a] &= pat(a, k);
      end
    check_all("R2 program");

    // R3 byte mode program, and word addresses fail in byte mode
    byte_mode = 1'b1;
    prog(1'b1, 16'h0003, 8'h0F); exp_mem[3] &= 8'h0F;
    prog(1'b0, 16'h0004, 8'h00);
    rd(16'h0003, v); check(v === exp_mem[3], "R3 byte prog", v, exp_mem[3]);
    rd(16'h0004, v); check(v === exp_mem[4], "R3 word addr in byte", v, exp_mem[4]);
    byte_mode = 1'b0;

    // R4 wrong address / wrong data
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h1234, 8'h55); bus_wr(16'h5555, 8'hA0); bus_wr(16'h0007, 8'h00);
    rd(16'h0007, v); check(v === exp_mem[7], "R4 bad addr", v, exp_mem[7]);
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h54); bus_wr(16'h5555, 8'hA0); bus_wr(16'h0007, 8'h00);
    rd(16'h0007, v); check(v === exp_mem[7], "R4 bad data", v, exp_mem[7]);
    erase(1'b0, 16'h5555, 8'h20);
    check(busy === 1'b0, "R4 bad confirm", busy, 0);

    // R5 abort mid sequence
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55); bus_wr(16'h0123, 8'hF0); bus_wr(16'h0008, 8'h00);
    rd(16'h0008, v); check(v === exp_mem[8], "R5 abort", v, exp_mem[8]);

    // R6 identification mode
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55); bus_wr(16'h5555, 8'h90);
    rd(16'h0000, v); check(v === 8'h40, "R6 mfr", v, 8'h40);
    rd(16'h0001, v); check(v === 8'hB3, "R6 dev", v, 8'hB3);
    rd(16'h0002, v); check(v === 8'h00, "R6 other", v, 0);
    bus_wr(16'h7777, 8'hF0);
    rd(16'h0000, v); check(v === exp_mem[0], "R5 leave ident", v, exp_mem[0]);

    // R11 strobes without chip enable
    bus_wr(16'h5555, 8'hAA, 1'b0); bus_wr(16'h2AAA, 8'h55, 1'b0);
    bus_wr(16'h5555, 8'hA0, 1'b0); bus_wr(16'h0009, 8'h00, 1'b0);
    rd(16'h0009, v); check(v === exp_mem[9], "R11 no ce", v, exp_mem[9]);

    // R7 chip erase with timed busy
    erase(1'b0, 16'h5555, 8'h10);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check(cnt == LEN - 1, "R7 busy length", cnt, LEN - 1);
    for (int i = 0; i < NC; i++) exp_mem[i] = 8'hFF;
    check_all("R7 chip erased");

    // R9 / R10 status and lockout during sector erase of sector 1
    for (int a = 0; a < NC; a++) begin prog(1'b0, 16'(a), pat(a, 2)); exp_mem[a] &= pat(a, 2); end
    erase(1'b0, 16'h0F05, 8'h30);
    rd(16'h0000, v); rd(16'h0000, v2);
    check(v[7] === 1'b0 && v2[7] === 1'b0, "R9 dq7", {v2[7], v[7]}, 0);
    check(v[6] !== v2[6], "R9 dq6 toggle", {v2[6], v[6]}, 1);
    check(v[5:0] === 6'd0, "R9 low bits", v[5:0], 0);
    prog(1'b0, 16'h0000, 8'h00);
    wait_idle();
    for (int i = 4; i < 8; i++) exp_mem[i] = 8'hFF;
    check_all("R10 lockout / R8 sector1");

    // R8 sector sweep, alternating modes
    for (int s = 0; s < 4; s++) begin
      byte_mode = s[0];
      for (int a = 0; a < NC; a++) begin prog(s[0], 16'(a), pat(a, s + 3)); exp_mem[a] &= pat(a, s + 3); end
      erase(s[0], 16'h3000 | 16'(s * 4 + s), 8'h30);
      wait_idle();
      for (int i = s * 4; i < s * 4 + 4; i++) exp_mem[i] = 8'hFF;
      check_all("R8 sector");
    end
    byte_mode = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule